// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable single-port SRAM with registered control, address and write paths, a registered read output, and a two-bit burst counter. By default it holds 256 words of 36 bits, split into four 9-bit lanes. Each lane is 8 data bits plus 1 parity bit. An access begins on a clock edge where one of two active-low address strobes is sampled low. One strobe is meant for a processor, and chip-enable gates it. The other is meant for a cache controller. Once an access has started, an advance input either steps through a wrapping group of four words or holds the current word. A static order input picks the stepping order: linear or interleaved.

A read returns its word on the data-out port one edge after the address is accepted. Deselection takes effect on the output with one cycle of delay. The output-enable qualifier (`dout_en`) goes low without waiting for a clock in three cases: the output-enable pin is high, a write is being presented, or the sleep input is high. Writes can cover all lanes at once (global write) or only the lanes picked by per-lane selects. A sleep input freezes every register and the array, and keeps their contents.

Top module: `burst_sram`

## Requirements
- R1: The device is selected when `ce_n`=0, `cs_hi`=1 and `cs_lo_n`=0. A start edge taken while not selected is a deselect: it writes nothing and ends the access. After that edge `dout_en` still presents the read accepted on the edge before. One edge later it is 0.
- R2: A low `adsp_n` has no effect while `ce_n`=1. With `adsc_n` high, such an edge acts as a burst-continue edge. When no access is open it does nothing.
- R3: `addr` is loaded when `adsc_n`=0, or when `adsp_n`=0 with `ce_n`=0. The word read at that address is on `dout` with `dout_en`=1 after the following edge. Back-to-back starts stream one word per edge.
- R4: On an edge where `adsp_n` starts the access, the write inputs are ignored and the edge is a read. A write presented on the next edge, with both strobes high, writes the loaded address.
- R5: On an edge with both strobes high and an access open, `adv_n`=0 moves to the next word of the group of four and `adv_n`=1 stays on the current word. This holds for reads and for writes. After four steps the address returns to the start word.
- R6: With `burst_ilv`=0, word k of an access lands at the start address with its low two bits replaced by (start[1:0]+k) mod 4.
- R7: With `burst_ilv`=1, word k lands at the start address with its low two bits replaced by start[1:0] XOR k.
- R8: `gw_n`=0 writes all four lanes, whatever `bwe_n` and `bw_n` hold.
- R9: With `gw_n`=1 and `bwe_n`=0, each lane n with `bw_n[n]`=0 is written and the other lanes keep their contents. With `bwe_n`=1 no lane is written.
- R10: Lane n is data bits 8n to 8n+7 together with bit 32+n.
- R11: `dout_en` is 0 at once whenever `oe_n`=1, or whenever a write is being presented that the next edge will take.
- R12: While `sleep`=1, no edge changes any register or the array, and `dout_en` is 0. When `sleep` returns low, the output shows what it showed before sleep.
- R13: After reset no access is open and `dout_en` is 0. Burst-continue and write inputs then have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low; also gates `adsp_n` |
| cs_hi | input | 1 | Chip select, active high |
| cs_lo_n | input | 1 | Chip select, active low |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Cache-controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Lane-write enable, active low |
| bw_n | input | 4 | Per-lane write selects, active low |
| oe_n | input | 1 | Output enable, active low, acts without the clock |
| sleep | input | 1 | Sleep, active high |
| burst_ilv | input | 1 | Burst order: 0 linear, 1 interleaved; static |
| addr | input | 8 | Word address |
| din | input | 36 | Write data |
| dout | output | 36 | Registered read data |
| dout_en | output | 1 | Output-driver enable for `dout` |

## Verification
A read accepted on edge T shows on `dout` after edge T+1. A write updates the array on the edge that takes it, so any read started later returns the new word. A deselect edge clears `dout_en` one edge after it. The output-enable pin, the write hazard and sleep clear `dout_en` with no edge at all. The bench drives inputs on the falling edge and samples on the falling edge that follows the edge being checked. It checks the asynchronous cases a few picoseconds after the input changes, with no clock in between. Expected words come from a bench-side image of the array, which each stimulus task updates using the lane layout and burst-order formulas.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

  // A burst walks through a group of four words.
  localparam int BURST_W = 2;

  // Low address bits for step `step` of a burst that began at `start`.
  function automatic logic [BURST_W-1:0] burst_ofs(
    input logic [BURST_W-1:0] start,
    input logic [BURST_W-1:0] step,
    input logic               ilv
  );
    return ilv ? (start ^ step) : (start + step);
  endfunction

endpackage

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep,
  input  logic              ce_n,
  input  logic              cs_hi,
  input  logic              cs_lo_n,
  input  logic              adsp_n,
  input  logic              adsc_n,
  input  logic              adv_n,
  input  logic              gw_n,
  input  logic              bwe_n,
  input  logic [LANES-1:0]  bw_n,
  input  logic              ilv,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_en,
  output logic [LANES-1:0]  wr_mask,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              rd_req_q,
  output logic [ADDR_W-1:0] rd_addr_q
);

  logic              sel, p_cyc, c_cyc, new_cyc, wr_ask, wr_now, rd_now;
  logic              active_q;
  logic [ADDR_W-1:0] base_q, base_sel;
  logic [BURST_W-1:0] step_q, step_nx, step_sel;

  always_comb begin
    sel     = !ce_n && cs_hi && !cs_lo_n;
    p_cyc   = !adsp_n && !ce_n;          // processor strobe, gated by chip enable
    c_cyc   = !p_cyc && !adsc_n;         // cache-controller strobe
    new_cyc = p_cyc || c_cyc;
    wr_ask  = !gw_n || (!bwe_n && !(&bw_n));
    wr_mask = !gw_n ? {LANES{1'b1}} : (!bwe_n ? ~bw_n : '0);
    step_nx = adv_n ? step_q : step_q + 1'b1;
    if (new_cyc) begin
      base_sel = addr;
      step_sel = '0;
      wr_now   = c_cyc && sel && wr_ask;  // processor start never writes
      rd_now   = sel && !wr_now;
    end else begin
      base_sel = base_q;
      step_sel = step_nx;
      wr_now   = active_q && wr_ask;
      rd_now   = active_q && !wr_now;
    end
    acc_addr = {base_sel[ADDR_W-1:BURST_W], burst_ofs(base_sel[BURST_W-1:0], step_sel, ilv)};
    wr_en    = wr_now && !sleep;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q  <= 1'b0;
      base_q    <= '0;
      step_q    <= '0;
      rd_req_q  <= 1'b0;
      rd_addr_q <= '0;
    end else if (!sleep) begin
      if (new_cyc) begin
        active_q <= sel;
        base_q   <= addr;
        step_q   <= '0;
      end else if (active_q) begin
        step_q <= step_nx;
      end
      rd_req_q  <= rd_now;
      rd_addr_q <= acc_addr;
    end
  end

endmodule

// File: rtl/burst_sram_array.sv
module burst_sram_array #(
  parameter  int ADDR_W = 8,
  parameter  int LANES  = 4,
  parameter  int BYTE_W = 8,
  localparam int DATA_W = LANES * (BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep,
  input  logic              we,
  input  logic [LANES-1:0]  wmask,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata,
  output logic              rvld
);

  localparam int DEPTH    = 1 << ADDR_W;
  localparam int LANE_W   = BYTE_W + 1;
  localparam int PAR_BASE = LANES * BYTE_W;

  for (genvar n = 0; n < LANES; n++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] wlane, rlane_q;

    assign wlane = {wdata[PAR_BASE+n], wdata[n*BYTE_W +: BYTE_W]};

    always_ff @(posedge clk) begin
      if (we && wmask[n]) mem[waddr] <= wlane;
    end

    always_ff @(posedge clk) begin
      if (rst)                  rlane_q <= '0;
      else if (!sleep && rd_req) rlane_q <= mem[raddr];
    end

    assign rdata[n*BYTE_W +: BYTE_W] = rlane_q[BYTE_W-1:0];
    assign rdata[PAR_BASE+n]         = rlane_q[BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (rst)         rvld <= 1'b0;
    else if (!sleep) rvld <= rd_req;
  end

endmodule

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter  int ADDR_W = 8,
  parameter  int LANES  = 4,
  parameter  int BYTE_W = 8,
  localparam int DATA_W = LANES * (BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              cs_hi,
  input  logic              cs_lo_n,
  input  logic              adsp_n,
  input  logic              adsc_n,
  input  logic              adv_n,
  input  logic              gw_n,
  input  logic              bwe_n,
  input  logic [LANES-1:0]  bw_n,
  input  logic              oe_n,
  input  logic              sleep,
  input  logic              burst_ilv,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);

  logic              wr_en, rd_req, rvld;
  logic [LANES-1:0]  wr_mask;
  logic [ADDR_W-1:0] acc_addr, rd_addr;

  burst_sram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk(clk), .rst(rst), .sleep(sleep),
    .ce_n(ce_n), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n),
    .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
    .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n),
    .ilv(burst_ilv), .addr(addr),
    .wr_en(wr_en), .wr_mask(wr_mask), .acc_addr(acc_addr),
    .rd_req_q(rd_req), .rd_addr_q(rd_addr)
  );

  burst_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .BYTE_W(BYTE_W)) u_array (
    .clk(clk), .rst(rst), .sleep(sleep),
    .we(wr_en), .wmask(wr_mask), .waddr(acc_addr), .wdata(din),
    .rd_req(rd_req), .raddr(rd_addr),
    .rdata(dout), .rvld(rvld)
  );

  // Output drivers: held off by the enable pin, by a write in progress and by sleep.
  assign dout_en = rvld && !oe_n && !wr_en && !sleep;

endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst,
  input logic              sleep,
  input logic              ce_n,
  input logic              cs_hi,
  input logic              cs_lo_n,
  input logic              adsp_n,
  input logic              adsc_n,
  input logic              adv_n,
  input logic [DATA_W-1:0] dout,
  input logic              dout_en,
  input logic              wr_en,
  input logic              rd_req,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rvld
);

  // R1
  desel_chk: assert property (@(posedge clk) disable iff (rst)
    (!sleep && ((!adsp_n && !ce_n) || !adsc_n) && !(!ce_n && cs_hi && !cs_lo_n)) |=> !rd_req);

  // R3
  rd_lat_chk: assert property (@(posedge clk) disable iff (rst)
    (!sleep && rd_req) |=> rvld);

  // R4
  adsp_nowr_chk: assert property (@(posedge clk) disable iff (rst)
    (!adsp_n && !ce_n) |-> !wr_en);

  // R5
  suspend_chk: assert property (@(posedge clk) disable iff (rst)
    (!sleep && rd_req && adsp_n && adsc_n && adv_n) |=> $stable(rd_addr));

  // R11
  wr_hiz_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !dout_en);

  // R12
  sleep_chk: assert property (@(posedge clk) disable iff (rst)
    sleep |=> ($stable(dout) && $stable(rd_addr) && $stable(rvld)));

endmodule

bind burst_sram burst_sram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .sleep(sleep),
  .ce_n(ce_n), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n),
  .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
  .dout(dout), .dout_en(dout_en), .wr_en(wr_en),
  .rd_req(rd_req), .rd_addr(rd_addr), .rvld(rvld)
);

// File: tb/test_burst_sram.sv
module test_burst_sram;
  localparam int AW = 8, LN = 4, BW = 8, DW = LN * (BW + 1), DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst, ce_n, cs_hi, cs_lo_n, adsp_n, adsc_n, adv_n, gw_n, bwe_n, oe_n, sleep, burst_ilv;
  logic [LN-1:0] bw_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] din, dout;
  logic          dout_en;

  burst_sram #(.ADDR_W(AW), .LANES(LN), .BYTE_W(BW)) i_burst_sram (
    .clk(clk), .rst(rst), .ce_n(ce_n), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n),
    .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n), .gw_n(gw_n), .bwe_n(bwe_n),
    .bw_n(bw_n), .oe_n(oe_n), .sleep(sleep), .burst_ilv(burst_ilv),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
  );

  always #10 clk = ~clk;

  int vecs = 0, errs = 0;
  bit done = 1'b0;
  logic [DW-1:0] ref_mem [DEPTH];

  function automatic logic [DW-1:0] pat(input int a, input int salt);
    return {4'(a + salt), 8'(a * 7 + salt), 8'(~a), 8'(a ^ salt ^ 8'h5A), 8'(a + 1)};
  endfunction

  // R10: lane n = bits 8n..8n+7 and bit 32+n
  function automatic logic [DW-1:0] lane_bits(input int m);
    logic [DW-1:0] v = '0;
    for (int n = 0; n < LN; n++) if (m[n]) begin
      v[8*n +: 8] = 8'hFF;
      v[32+n]     = 1'b1;
    end
    return v;
  endfunction

  // R6 / R7 burst address formulas
  function automatic int baddr(input int b, input int k, input int ilv);
    return (b & ~3) | (ilv != 0 ? ((b & 3) ^ (k & 3)) : (((b & 3) + k) & 3));
  endfunction

  task automatic dflt();
    ce_n = 0; cs_hi = 1; cs_lo_n = 0; adsp_n = 1; adsc_n = 1; adv_n = 1;
    gw_n = 1; bwe_n = 1; bw_n = '1; oe_n = 0; sleep = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_data(input string req, input logic [DW-1:0] exp);
    vecs++;
    if (!(dout_en === 1'b1 && dout === exp)) begin
      errs++;
      $display("FAIL %s: dout_en=%b dout=%h, expected dout_en=1 dout=%h", req, dout_en, dout, exp);
    end
  endtask

  task automatic check_hiz(input string req);
    vecs++;
    if (dout_en !== 1'b0) begin
      errs++;
      $display("FAIL %s: dout_en=%b, expected 0", req, dout_en);
    end
  endtask

  task automatic deselect();
    dflt(); ce_n = 1; adsc_n = 0;
    tick();
    dflt();
  endtask

  task automatic wr1(input int a, input logic [DW-1:0] d);
    dflt(); adsc_n = 0; addr = AW'(a); gw_n = 0; din = d;
    tick();
    ref_mem[a] = d;
    dflt();
  endtask

  task automatic rd_chk(input int a, input string req);
    dflt(); adsc_n = 0; addr = AW'(a);
    tick();
    dflt(); ce_n = 1; adsc_n = 0;
    tick();
    check_data(req, ref_mem[a]);
    tick();
    check_hiz("R1");
    dflt();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual run still busy, expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    dflt(); burst_ilv = 0; addr = '0; din = '0; rst = 1;
    repeat (3) tick();
    rst = 0;
    // R13 reset state and inert continue inputs
    check_hiz("R13");
    adv_n = 0; gw_n = 0; din = '1;
    tick(); tick();
    check_hiz("R13");
    dflt();

    for (int a = 0; a < DEPTH; a++) wr1(a, pat(a, 3));
    for (int a = 0; a < DEPTH; a++) rd_chk(a, "R3");

    // R3 back-to-back starts
    for (int a = 0; a < DEPTH; a++) begin
      dflt(); adsc_n = 0; addr = AW'(a);
      tick();
      if (a > 0) check_data("R3", ref_mem[a-1]);
    end
    deselect();

    // R5 R6 R7 bursts from every start in both orders, including wrap
    for (int m = 0; m < 2; m++) begin
      burst_ilv = m[0];
      for (int b = 0; b < DEPTH; b++) begin
        dflt(); adsc_n = 0; addr = AW'(b);
        tick();
        adsc_n = 1; adv_n = 0;
        for (int k = 0; k < 4; k++) begin
          tick();
          check_data(m != 0 ? "R7" : "R6", ref_mem[baddr(b, k, m)]);
        end
        dflt(); ce_n = 1; adsc_n = 0;
        tick();
        check_data("R5", ref_mem[baddr(b, 0, m)]);
        dflt();
      end
    end
    deselect();
    burst_ilv = 0;

    // R5 suspend: advance low, high, high, low
    begin
      int b = 5;
      dflt(); adsc_n = 0; addr = AW'(b); tick();
      adsc_n = 1; adv_n = 0; tick(); check_data("R5", ref_mem[baddr(b, 0, 0)]);
      adv_n = 1;             tick(); check_data("R5", ref_mem[baddr(b, 1, 0)]);
                             tick(); check_data("R5", ref_mem[baddr(b, 1, 0)]);
      adv_n = 0;             tick(); check_data("R5", ref_mem[baddr(b, 1, 0)]);
      dflt(); ce_n = 1; adsc_n = 0;
      tick(); check_data("R5", ref_mem[baddr(b, 2, 0)]);
      dflt();
    end

    // R2 processor strobe ignored while chip enable is high
    begin
      int b = 8;
      dflt(); adsc_n = 0; addr = AW'(b); tick();
      adsc_n = 1; ce_n = 1; adsp_n = 0; adv_n = 0; addr = 8'hF0;
      tick(); check_data("R2", ref_mem[baddr(b, 0, 0)]);
      tick(); check_data("R2", ref_mem[baddr(b, 1, 0)]);
      dflt(); ce_n = 1; adsc_n = 0;
      tick(); check_data("R2", ref_mem[baddr(b, 2, 0)]);
      dflt(); ce_n = 1; adsp_n = 0;
      tick(); check_hiz("R2");
      tick(); check_hiz("R2");
      dflt();
    end

    // R1 deselect variants, each with a write attempt
    for (int v = 0; v < 4; v++) begin
      int x = 100 + v;
      dflt(); adsc_n = 0; addr = AW'(x); tick();
      dflt(); gw_n = 0; din = ~ref_mem[x];
      case (v)
        0: begin cs_hi = 0;   adsc_n = 0; end
        1: begin cs_lo_n = 1; adsc_n = 0; end
        2: begin ce_n = 1;    adsc_n = 0; end
        default: begin cs_hi = 0; adsp_n = 0; end
      endcase
      tick(); check_data("R1", ref_mem[x]);
      dflt();
      tick(); check_hiz("R1");
      rd_chk(x, "R1");
    end

    // R4 processor-started access: write controls ignored, taken next edge
    begin
      int x = 20;
      logic [DW-1:0] old_v, new_v;
      old_v = ref_mem[x]; new_v = pat(x, 99);
      dflt(); adsp_n = 0; addr = AW'(x); gw_n = 0; din = new_v;
      tick();
      adsp_n = 1;
      tick();
      check_hiz("R11");
      gw_n = 1; #1;
      check_data("R4", old_v);
      ref_mem[x] = new_v;
      tick(); tick();
      check_data("R4", new_v);
      deselect();
      rd_chk(x, "R4");
    end

    // R8 R9 R10 lane writes
    for (int m = 0; m < 16; m++) begin
      logic [DW-1:0] p, q;
      p = pat(40, m); q = ~p;
      wr1(40, p);
      dflt(); adsc_n = 0; addr = 8'd40; bwe_n = 0; bw_n = 4'(~m); din = q;
      tick(); dflt();
      ref_mem[40] = (p & ~lane_bits(m)) | (q & lane_bits(m));
      rd_chk(40, $countones(m) == 1 ? "R10" : "R9");
      wr1(40, p);
      dflt(); adsc_n = 0; addr = 8'd40; bwe_n = 1; bw_n = '0; din = q;
      tick(); dflt();
      rd_chk(40, "R9");
      dflt(); adsc_n = 0; addr = 8'd40; gw_n = 0; bwe_n = m[0]; bw_n = 4'(m); din = q;
      tick(); dflt();
      ref_mem[40] = q;
      rd_chk(40, "R8");
    end

    // R5 R7 burst write with one suspended step
    begin
      int b = 8'h62;
      burst_ilv = 1;
      dflt(); adsc_n = 0; addr = AW'(b); gw_n = 0; din = pat(1, 1);
      tick(); ref_mem[baddr(b, 0, 1)] = pat(1, 1);
      adsc_n = 1; adv_n = 0; din = pat(2, 2);
      tick(); ref_mem[baddr(b, 1, 1)] = pat(2, 2);
      adv_n = 1; din = pat(3, 3);
      tick(); ref_mem[baddr(b, 1, 1)] = pat(3, 3);
      adv_n = 0; din = pat(4, 4);
      tick(); ref_mem[baddr(b, 2, 1)] = pat(4, 4);
      deselect();
      for (int k = 0; k < 4; k++) rd_chk(baddr(b, k, 1), "R7");
      burst_ilv = 0;
    end

    // R11 output enable acts without a clock
    dflt(); adsc_n = 0; addr = 8'd7; tick();
    dflt(); tick();
    check_data("R11", ref_mem[7]);
    oe_n = 1; #1; check_hiz("R11");
    oe_n = 0; #1; check_data("R11", ref_mem[7]);
    deselect();

    // R12 sleep freezes state and keeps contents
    begin
      int b = 8'h80;
      dflt(); adsc_n = 0; addr = AW'(b); tick();
      adsc_n = 1; adv_n = 0; tick();
      sleep = 1; gw_n = 0; din = '1; #1;
      check_hiz("R12");
      for (int i = 0; i < 3; i++) begin tick(); check_hiz("R12"); end
      sleep = 0; gw_n = 1; adv_n = 1; #1;
      check_data("R12", ref_mem[b]);
      deselect();
      rd_chk(baddr(b, 1, 0), "R12");
      rd_chk(baddr(b, 2, 0), "R12");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule